// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions

This block is the tag and state array of a cache controller. The array is split into sets, and each set holds a fixed number of ways. Every way keeps a line tag and a two-bit access permission. The controller sends one command per cycle on a single port. A command can look up a line, check whether it may use the line, reserve a way for a new line, release a line, change a line's permission, refresh a line's recency, or ask which line would be replaced. The data payload, the policy that chooses permissions, and any hashing of addresses are handled outside this block.

The set is chosen by the low `SET_BITS` bits of the line address. The rest of the address is the stored tag. All results are combinational in the cycle the command is presented. All state changes take effect at the next rising clock edge. Replacement is true LRU, kept as one age counter per way in each set.

Top module: `tagdir_top`

## Requirements
- R1: After reset, every way of every set is absent (permission code 0) with tag zero. Lookups miss, availability is 1, and the victim address of set s is `{0, s}`.
- R2: A way matches only when its stored tag equals the request tag and its permission is not absent. On no match, `found`=0, `hit_way`=0 and `cur_perm`=0. The set is the low `SET_BITS` bits of `line_addr`.
- R3: An access command (op 1) with request kind load=0, store=1, fetch=2 or atomic=3 sets `hit` when the matched way is read-write (code 3).
- R4: An access to a read-only way (code 2) sets `hit` only for load and fetch. Store and atomic report a miss, and so does a way in the invalid state (code 1).
- R5: An access or test command that finds a matching way refreshes that way as most recently used, even when the permission check fails.
- R6: Test (op 2) and present (op 3) commands set `hit` whenever a matching way exists, whatever the request kind and permission.
- R7: `avail` is 1 when any way of the set holds an equal tag, whatever its permission, or when any way of the set is absent.
- R8: Allocate (op 5) writes the tag into the lowest-numbered absent way. It sets that way to invalid (code 1) and makes it most recently used.
- R9: Deallocate (op 6) sets the matched way to absent. Set-permission (op 7) writes `new_perm` into the matched way. Mark-MRU (op 9) refreshes the matched way.
- R10: `victim_addr` is `{tag, set}` of the least recently used way in the addressed set. Right after reset the ways are ordered so that way 0 is the victim. Probe (op 8) is legal only when `avail` is 0.
- R11: `cmd_err` is 1 in the cycle of any of these illegal commands:
  - an allocate whose tag is already present, or with no available way;
  - a deallocate or set-permission that finds no match;
  - a probe while `avail` is 1.
  An illegal command changes no state.
- R12: Lookup results appear in the command cycle. A state change is visible to a command presented after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code (0 idle, 1 access, 2 test, 3 present, 4 avail, 5 alloc, 6 dealloc, 7 set-perm, 8 probe, 9 mark-MRU) |
| req_kind | input | 2 | Request kind: 0 load, 1 store, 2 fetch, 3 atomic |
| line_addr | input | ADDR_W | Line address; low SET_BITS bits select the set |
| new_perm | input | 2 | Permission written by set-perm |
| hit | output | 1 | Access/test/present succeeded |
| hit_way | output | WAY_W | Matched way, 0 when none |
| found | output | 1 | A live way holds the request tag |
| avail | output | 1 | Equal tag or absent way exists in the set |
| cur_perm | output | 2 | Permission of the matched way, 0 when none |
| victim_addr | output | ADDR_W | Line address of the LRU way in the set |
| cmd_err | output | 1 | Illegal command this cycle |

## Verification
`hit`, `hit_way`, `found`, `avail`, `cur_perm`, `victim_addr` and `cmd_err` are due in the same cycle as the command. Tag, permission and recency changes are due one rising edge later. The bench drives each command at a falling edge and samples the outputs 2 ns later, before the rising edge that commits the command. It then observes each committed effect, including the absence of one after an illegal command, through a later present, avail or probe command.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [1:0] {
    PERM_ABSENT = 2'd0,
    PERM_STALE  = 2'd1,
    PERM_RD     = 2'd2,
    PERM_RDWR   = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    KIND_LOAD   = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_FETCH  = 2'd2,
    KIND_ATOMIC = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    OP_IDLE    = 4'd0,
    OP_ACCESS  = 4'd1,
    OP_TEST    = 4'd2,
    OP_PRESENT = 4'd3,
    OP_AVAIL   = 4'd4,
    OP_ALLOC   = 4'd5,
    OP_DEALLOC = 4'd6,
    OP_SETPERM = 4'd7,
    OP_PROBE   = 4'd8,
    OP_MRU     = 4'd9
  } op_e;
endpackage

// File: rtl/tagdir_match.sv
module tagdir_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 14,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0][1:0]       way_perm,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       found,
  output logic [WAY_W-1:0]           match_way,
  output logic [1:0]                 match_perm,
  output logic                       avail,
  output logic                       free_found,
  output logic [WAY_W-1:0]           free_way
);
  import tagdir_pkg::*;

  logic [WAYS-1:0] tag_eq;
  logic [WAYS-1:0] absent;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign tag_eq[w] = (way_tag[w] == req_tag);
    assign absent[w] = (way_perm[w] == PERM_ABSENT);
  end

  // Scan high to low so the lowest-numbered candidate wins.
  always_comb begin
    found      = 1'b0;
    match_way  = '0;
    match_perm = PERM_ABSENT;
    free_found = 1'b0;
    free_way   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (tag_eq[i] && !absent[i]) begin
        found      = 1'b1;
        match_way  = WAY_W'(i);
        match_perm = way_perm[i];
      end
      if (absent[i]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(i);
      end
    end
  end

  assign avail = (|tag_eq) || (|absent);
endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] sel_set,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  is_oldest;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(WAYS - 1 - w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[sel_set][w] <= '0;
        else if (age_q[sel_set][w] < age_q[sel_set][touch_way])
          age_q[sel_set][w] <= age_q[sel_set][w] + 1'b1;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign is_oldest[w] = (age_q[sel_set][w] == OLDEST);
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (is_oldest[w]) victim_way = WAY_W'(w);
  end

  // R10: ages stay a permutation, so exactly one way is the victim
  assert_single_victim_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(is_oldest) == 1);

  // R5: a touched way becomes the youngest
  assert_touch_youngest_R5: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> age_q[$past(sel_set)][$past(touch_way)] == '0);
endmodule

// File: rtl/tagdir_top.sv
module tagdir_top #(
  parameter int SET_BITS = 2,
  parameter int WAYS     = 4,
  parameter int ADDR_W   = 16,
  localparam int SETS  = 1 << SET_BITS,
  localparam int TAG_W = ADDR_W - SET_BITS,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] line_addr,
  input  logic [1:0]        new_perm,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic              found,
  output logic              avail,
  output logic [1:0]        cur_perm,
  output logic [ADDR_W-1:0] victim_addr,
  output logic              cmd_err
);
  import tagdir_pkg::*;

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [1:0]       perm_q [SETS][WAYS];

  logic [SET_BITS-1:0] set_idx;
  logic [TAG_W-1:0]    req_tag;
  op_e                 op;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][1:0]       rd_perm;

  logic             free_found;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] victim_way;
  logic             touch_en;
  logic [WAY_W-1:0] touch_way;
  logic             commit;

  assign set_idx = line_addr[SET_BITS-1:0];
  assign req_tag = line_addr[ADDR_W-1:SET_BITS];
  assign op      = op_e'(cmd_op);

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tag[w]  = tag_q[set_idx][w];
    assign rd_perm[w] = perm_q[set_idx][w];
  end

  tagdir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_tag    (rd_tag),
    .way_perm   (rd_perm),
    .req_tag    (req_tag),
    .found      (found),
    .match_way  (hit_way),
    .match_perm (cur_perm),
    .avail      (avail),
    .free_found (free_found),
    .free_way   (free_way)
  );

  tagdir_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .sel_set    (set_idx),
    .touch_en   (touch_en),
    .touch_way  (touch_way),
    .victim_way (victim_way)
  );

  assign victim_addr = {tag_q[set_idx][victim_way], set_idx};

  // Hit qualification by command and request kind
  always_comb begin
    hit = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_ACCESS: hit = found && ((cur_perm == PERM_RDWR) ||
                         ((cur_perm == PERM_RD) &&
                          ((req_kind == KIND_LOAD) || (req_kind == KIND_FETCH))));
        OP_TEST, OP_PRESENT: hit = found;
        default: hit = 1'b0;
      endcase
    end
  end

  // Illegal command detection
  always_comb begin
    cmd_err = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_ALLOC:              cmd_err = found || !avail || !free_found;
        OP_DEALLOC, OP_SETPERM: cmd_err = !found;
        OP_PROBE:              cmd_err = avail;
        default:               cmd_err = 1'b0;
      endcase
    end
  end

  assign commit = cmd_valid && !cmd_err;

  always_comb begin
    touch_en  = 1'b0;
    touch_way = hit_way;
    if (commit) begin
      case (op)
        OP_ACCESS, OP_TEST, OP_MRU: touch_en = found;
        OP_ALLOC: begin
          touch_en  = 1'b1;
          touch_way = free_way;
        end
        default: touch_en = 1'b0;
      endcase
    end
  end

  // Tag and permission storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          perm_q[s][w] <= PERM_ABSENT;
        end
    end else if (commit) begin
      case (op)
        OP_ALLOC: begin
          tag_q[set_idx][free_way]  <= req_tag;
          perm_q[set_idx][free_way] <= PERM_STALE;
        end
        OP_DEALLOC: perm_q[set_idx][hit_way] <= PERM_ABSENT;
        OP_SETPERM: perm_q[set_idx][hit_way] <= new_perm;
        default: ;
      endcase
    end
  end

  // R2: a miss reports way 0 and the absent permission
  assert_miss_defaults_R2: assert property (@(posedge clk) disable iff (rst)
    !found |-> (hit_way == '0) && (cur_perm == PERM_ABSENT));

  // R3: no hit without a live matching way
  assert_hit_needs_match_R3: assert property (@(posedge clk) disable iff (rst)
    hit |-> found);

  // R4: stores never hit a read-only way
  assert_ro_store_miss_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_ACCESS && cur_perm == PERM_RD &&
     (req_kind == KIND_STORE || req_kind == KIND_ATOMIC)) |-> !hit);

  // R8: an allocated way becomes invalid with the request tag
  assert_alloc_writes_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_ALLOC && !cmd_err) |=>
      (perm_q[$past(set_idx)][$past(free_way)] == PERM_STALE) &&
      (tag_q[$past(set_idx)][$past(free_way)] == $past(req_tag)));

  // R9: deallocate leaves the way absent
  assert_dealloc_absent_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_DEALLOC && !cmd_err) |=>
      perm_q[$past(set_idx)][$past(hit_way)] == PERM_ABSENT);

  // R11: probing while a way is available is flagged
  assert_probe_illegal_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_PROBE && avail) |-> cmd_err);
endmodule

// File: tb/sim_tagdir_top.sv
module sim_tagdir_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [1:0]  req_kind;
  logic [15:0] line_addr;
  logic [1:0]  new_perm;
  logic        hit;
  logic [1:0]  hit_way;
  logic        found;
  logic        avail;
  logic [1:0]  cur_perm;
  logic [15:0] victim_addr;
  logic        cmd_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [3:0] ACC = 4'd1, TST = 4'd2, PRS = 4'd3, AVL = 4'd4,
                         ALC = 4'd5, DEA = 4'd6, SPM = 4'd7, PRB = 4'd8, MRU = 4'd9;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, IF = 2'd2;
  localparam logic [1:0] P_NP = 2'd0, P_INV = 2'd1, P_RO = 2'd2, P_RW = 2'd3;

  always #5 clk = ~clk;

  tagdir_top u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .req_kind(req_kind), .line_addr(line_addr), .new_perm(new_perm),
    .hit(hit), .hit_way(hit_way), .found(found), .avail(avail),
    .cur_perm(cur_perm), .victim_addr(victim_addr), .cmd_err(cmd_err)
  );

  function automatic logic [15:0] mk(input logic [13:0] tag, input logic [1:0] set);
    return {tag, set};
  endfunction

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  // One command per call: driven at a falling edge, sampled 2 ns later,
  // committed at the following rising edge.
  task automatic cmd(input logic [3:0] op, input logic [13:0] tag, input logic [1:0] set,
                     input logic [1:0] kind, input logic [1:0] perm);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    line_addr = mk(tag, set);
    req_kind  = kind;
    new_perm  = perm;
    #2;
  endtask

  task automatic t_reset;
    cmd(PRS, 14'd0, 2'd0, LD, P_NP);
    chk("R1 found after reset", found, 0);
    chk("R1 avail after reset", avail, 1);
    chk("R1 victim set0", victim_addr, mk(0, 0));
    chk("R2 miss way", hit_way, 0);
    chk("R2 miss perm", cur_perm, P_NP);
    cmd(PRB, 14'd3, 2'd2, LD, P_NP);
    chk("R1 victim set2", victim_addr, mk(0, 2));
  endtask

  task automatic t_fill;
    cmd(ALC, 14'd5, 2'd1, LD, P_NP);
    chk("R12 alloc cycle not yet present", found, 0);
    chk("R8 alloc legal", cmd_err, 0);
    cmd(PRS, 14'd5, 2'd1, ST, P_NP);
    chk("R12 present after edge", hit, 1);
    chk("R8 alloc way0", hit_way, 0);
    chk("R8 alloc perm invalid", cur_perm, P_INV);
    cmd(ACC, 14'd5, 2'd1, LD, P_NP);
    chk("R4 invalid access miss", hit, 0);
    cmd(TST, 14'd5, 2'd1, ST, P_NP);
    chk("R6 test hits invalid", hit, 1);
    cmd(PRS, 14'd5, 2'd2, LD, P_NP);
    chk("R2 other set no match", found, 0);
    cmd(ALC, 14'd6, 2'd1, LD, P_NP);
    cmd(ALC, 14'd7, 2'd1, LD, P_NP);
    cmd(ALC, 14'd8, 2'd1, LD, P_NP);
    cmd(PRS, 14'd8, 2'd1, LD, P_NP);
    chk("R8 fourth alloc way3", hit_way, 3);
    cmd(AVL, 14'd9, 2'd1, LD, P_NP);
    chk("R7 full set not avail", avail, 0);
    cmd(AVL, 14'd6, 2'd1, LD, P_NP);
    chk("R7 equal tag avail", avail, 1);
    cmd(PRB, 14'd9, 2'd1, LD, P_NP);
    chk("R10 probe legal", cmd_err, 0);
    chk("R10 victim oldest", victim_addr, mk(5, 1));
  endtask

  task automatic t_perm;
    cmd(SPM, 14'd5, 2'd1, LD, P_RO);
    chk("R9 setperm legal", cmd_err, 0);
    cmd(ACC, 14'd5, 2'd1, ST, P_NP);
    chk("R4 store on read-only misses", hit, 0);
    chk("R9 perm written", cur_perm, P_RO);
    cmd(PRB, 14'd9, 2'd1, LD, P_NP);
    chk("R5 failed access refreshes", victim_addr, mk(6, 1));
    cmd(ACC, 14'd5, 2'd1, LD, P_NP);
    chk("R4 load on read-only hits", hit, 1);
    cmd(ACC, 14'd5, 2'd1, IF, P_NP);
    chk("R4 fetch on read-only hits", hit, 1);
    cmd(ACC, 14'd5, 2'd1, 2'd3, P_NP);
    chk("R4 atomic on read-only misses", hit, 0);
    cmd(SPM, 14'd6, 2'd1, LD, P_RW);
    cmd(ACC, 14'd6, 2'd1, ST, P_NP);
    chk("R3 store on read-write hits", hit, 1);
    chk("R3 way", hit_way, 1);
    cmd(ACC, 14'd6, 2'd1, 2'd3, P_NP);
    chk("R3 atomic on read-write hits", hit, 1);
    cmd(PRB, 14'd9, 2'd1, LD, P_NP);
    chk("R5 victim after store", victim_addr, mk(7, 1));
    cmd(MRU, 14'd7, 2'd1, LD, P_NP);
    cmd(PRB, 14'd9, 2'd1, LD, P_NP);
    chk("R9 mark MRU moves victim", victim_addr, mk(8, 1));
  endtask

  task automatic t_errors;
    cmd(ALC, 14'd5, 2'd1, LD, P_NP);
    chk("R11 alloc present", cmd_err, 1);
    cmd(ALC, 14'd10, 2'd1, LD, P_NP);
    chk("R11 alloc full", cmd_err, 1);
    cmd(DEA, 14'd10, 2'd1, LD, P_NP);
    chk("R11 dealloc miss", cmd_err, 1);
    cmd(SPM, 14'd10, 2'd1, LD, P_RW);
    chk("R11 setperm miss", cmd_err, 1);
    cmd(PRB, 14'd1, 2'd2, LD, P_NP);
    chk("R11 probe while avail", cmd_err, 1);
    cmd(PRS, 14'd10, 2'd1, LD, P_NP);
    chk("R11 failed alloc wrote nothing", found, 0);
    cmd(PRS, 14'd5, 2'd1, LD, P_NP);
    chk("R11 perm unchanged", cur_perm, P_RO);
    cmd(PRB, 14'd10, 2'd1, LD, P_NP);
    chk("R11 recency unchanged", victim_addr, mk(8, 1));
  endtask

  task automatic t_release;
    cmd(DEA, 14'd7, 2'd1, LD, P_NP);
    chk("R9 dealloc legal", cmd_err, 0);
    cmd(PRS, 14'd7, 2'd1, LD, P_NP);
    chk("R9 dealloc absent", found, 0);
    chk("R2 absent tag no match", hit, 0);
    cmd(AVL, 14'd10, 2'd1, LD, P_NP);
    chk("R7 absent way avail", avail, 1);
    cmd(ALC, 14'd9, 2'd1, LD, P_NP);
    cmd(PRS, 14'd9, 2'd1, LD, P_NP);
    chk("R8 lowest absent way", hit_way, 2);
    chk("R8 perm invalid", cur_perm, P_INV);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; req_kind = '0;
    line_addr = '0; new_perm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_fill;
    t_perm;
    t_errors;
    t_release;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule